// File: doc/BRIEF.md
# Multi-Candidate Binding Controller

This block sequences a fixed datapath schedule over a bank of ALUs and a bank of multipliers. Each run walks a fixed number of single-cycle control steps. In every step it raises one activation enable for each functional unit that performs an operation in that step. The schedule itself never changes: the number of ALU operations and multiplier operations in each step is the same for every binding candidate. What differs between candidates is which physical units of a type carry those operations. This lets a part whose units have uneven power characteristics run the schedule on its cheaper units.

A single reference sequencer produces the enables of the base candidate (candidate 0). A remap stage, indexed by candidate number and control step, rotates those enables onto the units of the chosen candidate. A routing stage then drives each active unit's operand from the operation slot it serves. A unit that is not enabled is held at a constant low-leakage operand vector.

The candidate select is programmed once after fabrication and is held steady. The controller samples it when a run is started. The interface is plain control: a start pulse begins a run while the controller is idle, and a one-cycle done pulse ends it. There is no back-pressure; operand slots are sampled combinationally in each step.

Top module: `bind_ctrl`

## Requirements
- R1: While reset is held and after it is released, busy_o and done_o are 0, all enables are 0, and every unit operand output equals its type's low-leakage vector (ALU 16'h5A3C, multiplier 16'hC3A5).
- R2: A start_i sampled high at a rising edge while idle makes busy_o 1 with step_o 0 after that edge. step_o then rises by one per cycle through N_STEPS-1.
- R3: The cycle after the last step, done_o is 1 for exactly one cycle, busy_o is 0 and all enables are 0. The controller then stays idle until the next start.
- R4: start_i sampled while busy_o is 1 has no effect on the step sequence or on the run length, and does not begin a new run after done.
- R5: In step s the base candidate enables ALUs 0 to A(s)-1 and multipliers 0 to M(s)-1, where A(s) = (5s+3) mod (N_ALU+1) and M(s) = (3s+2) mod (N_MUL+1).
- R6: For candidate c in step s, ALU u is enabled exactly when base ALU (u + c*(s+1)) mod N_ALU is enabled. Multiplier u is enabled exactly when base multiplier (u + c*(s+2)) mod N_MUL is enabled. Candidate 0 therefore reproduces the base enables unchanged.
- R7: For every candidate and step, the number of enabled ALUs equals A(s) and the number of enabled multipliers equals M(s).
- R8: A select value of N_CAND or above runs the base candidate.
- R9: The select is latched at start. Changing cand_sel_i during a run does not change that run's enables.
- R10: An enabled unit of a type drives the operand of slot k from its type's bus, where k is the count of enabled units of that type with a lower index. Its slot output equals k. A disabled unit drives the low-leakage vector and slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run when idle |
| cand_sel_i | input | SEL_W (5) | Post-fabrication candidate select |
| alu_bus_i | input | N_ALU*OPW (192) | ALU operand per operation slot, slot k at bits k*OPW |
| mul_bus_i | input | N_MUL*OPW (128) | Multiplier operand per operation slot |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| step_o | output | STEP_W (3) | Current control step |
| alu_en_o | output | N_ALU (12) | ALU activation enables |
| mul_en_o | output | N_MUL (8) | Multiplier activation enables |
| alu_slot_o | output | N_ALU*SLA_W (48) | Per-ALU operand mux select |
| mul_slot_o | output | N_MUL*SLM_W (24) | Per-multiplier operand mux select |
| alu_opnd_o | output | N_ALU*OPW (192) | Per-ALU operand, forced when idle |
| mul_opnd_o | output | N_MUL*OPW (128) | Per-multiplier operand, forced when idle |

## Verification
The assertions assume that reset is applied before the first start. They make no assumption about the select or the bus data: the remap and routing stages must give correct counts and forced operands for any value. Because the select is latched at start, a change during a run is legal, and the stimulus uses it on purpose. It also raises start in the middle of a run and on the last step, to cover the case where start is ignored. The stimulus covers every in-range candidate and several out-of-range selects.

// File: rtl/bind_pkg.sv
package bind_pkg;
  // Scheduled operation count of one unit type in control step s
  function automatic int sched_cnt(input int s, input int mulf, input int addf, input int n);
    return (s * mulf + addf) % (n + 1);
  endfunction

  localparam int ALU_MULF = 5;
  localparam int ALU_ADDF = 3;
  localparam int MUL_MULF = 3;
  localparam int MUL_ADDF = 2;
  localparam int ALU_KOFF = 1;
  localparam int MUL_KOFF = 2;
endpackage

// File: rtl/bind_seq.sv
module bind_seq #(
  parameter int N_ALU   = 12,
  parameter int N_MUL   = 8,
  parameter int N_STEPS = 8,
  parameter int N_CAND  = 24,
  parameter int SEL_W   = 5,
  parameter int STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  cand_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o,
  output logic [SEL_W-1:0]  cand_o,
  output logic [N_ALU-1:0]  alu_ref_o,
  output logic [N_MUL-1:0]  mul_ref_o
);
  import bind_pkg::*;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  logic [SEL_W-1:0] sel_eff;
  assign sel_eff = (int'(cand_sel_i) >= N_CAND) ? '0 : cand_sel_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_o <= '0;
      cand_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          step_o <= '0;
          cand_o <= sel_eff;
        end
      end else if (step_o == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        step_o <= '0;
      end else begin
        step_o <= step_o + 1'b1;
      end
    end
  end

  int alu_cnt, mul_cnt;
  always_comb begin
    alu_cnt = sched_cnt(int'(step_o), ALU_MULF, ALU_ADDF, N_ALU);
    mul_cnt = sched_cnt(int'(step_o), MUL_MULF, MUL_ADDF, N_MUL);
    alu_ref_o = '0;
    mul_ref_o = '0;
    for (int u = 0; u < N_ALU; u++) alu_ref_o[u] = busy_o && (u < alu_cnt);
    for (int u = 0; u < N_MUL; u++) mul_ref_o[u] = busy_o && (u < mul_cnt);
  end
endmodule

// File: rtl/bind_remap.sv
module bind_remap #(
  parameter int N      = 12,
  parameter int KOFF   = 1,
  parameter int SEL_W  = 5,
  parameter int STEP_W = 3
) (
  input  logic [SEL_W-1:0]  cand_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [N-1:0]      ref_i,
  output logic [N-1:0]      en_o
);
  int rot;
  always_comb begin
    rot = (int'(cand_i) * (int'(step_i) + KOFF)) % N;
    for (int u = 0; u < N; u++) en_o[u] = ref_i[(u + rot) % N];
  end
endmodule

// File: rtl/bind_route.sv
module bind_route #(
  parameter int          N      = 12,
  parameter int          OPW    = 16,
  parameter int          SLOT_W = 4,
  parameter logic [15:0] LEAK   = 16'h5A3C
) (
  input  logic [N-1:0]              en_i,
  input  logic [N-1:0][OPW-1:0]     bus_i,
  output logic [N-1:0][SLOT_W-1:0]  slot_o,
  output logic [N-1:0][OPW-1:0]     opnd_o
);
  int rank;
  always_comb begin
    rank = 0;
    for (int u = 0; u < N; u++) begin
      slot_o[u] = '0;
      opnd_o[u] = OPW'(LEAK);
      if (en_i[u]) begin
        slot_o[u] = SLOT_W'(rank);
        opnd_o[u] = bus_i[rank];
        rank      = rank + 1;
      end
    end
  end
endmodule

// File: rtl/bind_ctrl.sv
module bind_ctrl #(
  parameter int          N_ALU    = 12,
  parameter int          N_MUL    = 8,
  parameter int          N_STEPS  = 8,
  parameter int          N_CAND   = 24,
  parameter int          SEL_W    = 5,
  parameter int          OPW      = 16,
  parameter logic [15:0] LEAK_ALU = 16'h5A3C,
  parameter logic [15:0] LEAK_MUL = 16'hC3A5,
  localparam int         STEP_W   = (N_STEPS > 1) ? $clog2(N_STEPS) : 1,
  localparam int         SLA_W    = $clog2(N_ALU),
  localparam int         SLM_W    = $clog2(N_MUL)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [SEL_W-1:0]           cand_sel_i,
  input  logic [N_ALU-1:0][OPW-1:0]  alu_bus_i,
  input  logic [N_MUL-1:0][OPW-1:0]  mul_bus_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [STEP_W-1:0]          step_o,
  output logic [N_ALU-1:0]           alu_en_o,
  output logic [N_MUL-1:0]           mul_en_o,
  output logic [N_ALU-1:0][SLA_W-1:0] alu_slot_o,
  output logic [N_MUL-1:0][SLM_W-1:0] mul_slot_o,
  output logic [N_ALU-1:0][OPW-1:0]  alu_opnd_o,
  output logic [N_MUL-1:0][OPW-1:0]  mul_opnd_o
);
  import bind_pkg::*;

  logic [SEL_W-1:0] cand_q;
  logic [N_ALU-1:0] alu_ref;
  logic [N_MUL-1:0] mul_ref;

  bind_seq #(
    .N_ALU(N_ALU), .N_MUL(N_MUL), .N_STEPS(N_STEPS), .N_CAND(N_CAND),
    .SEL_W(SEL_W), .STEP_W(STEP_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cand_sel_i(cand_sel_i),
    .busy_o(busy_o), .done_o(done_o), .step_o(step_o), .cand_o(cand_q),
    .alu_ref_o(alu_ref), .mul_ref_o(mul_ref)
  );

  bind_remap #(.N(N_ALU), .KOFF(ALU_KOFF), .SEL_W(SEL_W), .STEP_W(STEP_W)) u_remap_alu (
    .cand_i(cand_q), .step_i(step_o), .ref_i(alu_ref), .en_o(alu_en_o)
  );

  bind_remap #(.N(N_MUL), .KOFF(MUL_KOFF), .SEL_W(SEL_W), .STEP_W(STEP_W)) u_remap_mul (
    .cand_i(cand_q), .step_i(step_o), .ref_i(mul_ref), .en_o(mul_en_o)
  );

  bind_route #(.N(N_ALU), .OPW(OPW), .SLOT_W(SLA_W), .LEAK(LEAK_ALU)) u_route_alu (
    .en_i(alu_en_o), .bus_i(alu_bus_i), .slot_o(alu_slot_o), .opnd_o(alu_opnd_o)
  );

  bind_route #(.N(N_MUL), .OPW(OPW), .SLOT_W(SLM_W), .LEAK(LEAK_MUL)) u_route_mul (
    .en_i(mul_en_o), .bus_i(mul_bus_i), .slot_o(mul_slot_o), .opnd_o(mul_opnd_o)
  );
endmodule

// File: rtl/bind_ctrl_chk.sv
module bind_ctrl_chk #(
  parameter int          N_ALU    = 12,
  parameter int          N_MUL    = 8,
  parameter int          N_STEPS  = 8,
  parameter int          OPW      = 16,
  parameter logic [15:0] LEAK_ALU = 16'h5A3C,
  parameter logic [15:0] LEAK_MUL = 16'hC3A5,
  parameter int          STEP_W   = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start_i,
  input logic                      busy_o,
  input logic                      done_o,
  input logic [STEP_W-1:0]         step_o,
  input logic [N_ALU-1:0]          alu_en_o,
  input logic [N_MUL-1:0]          mul_en_o,
  input logic [N_ALU-1:0][OPW-1:0] alu_opnd_o,
  input logic [N_MUL-1:0][OPW-1:0] mul_opnd_o
);
  import bind_pkg::*;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  a_r2_start_step0: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && step_o == '0));

  a_r2_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_o != LAST) |=> (busy_o && step_o == $past(step_o) + 1'b1));

  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && step_o == LAST) |=> (done_o && !busy_o));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (alu_en_o == '0 && mul_en_o == '0));

  a_r7_alu_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(alu_en_o) == sched_cnt(int'(step_o), ALU_MULF, ALU_ADDF, N_ALU)));

  a_r7_mul_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(mul_en_o) == sched_cnt(int'(step_o), MUL_MULF, MUL_ADDF, N_MUL)));

  for (genvar u = 0; u < N_ALU; u++) begin : g_alu_leak
    a_r10_alu_leak: assert property (@(posedge clk) disable iff (!rst_n)
      !alu_en_o[u] |-> (alu_opnd_o[u] == OPW'(LEAK_ALU)));
  end
  for (genvar u = 0; u < N_MUL; u++) begin : g_mul_leak
    a_r10_mul_leak: assert property (@(posedge clk) disable iff (!rst_n)
      !mul_en_o[u] |-> (mul_opnd_o[u] == OPW'(LEAK_MUL)));
  end
endmodule

bind bind_ctrl bind_ctrl_chk #(
  .N_ALU(N_ALU), .N_MUL(N_MUL), .N_STEPS(N_STEPS), .OPW(OPW),
  .LEAK_ALU(LEAK_ALU), .LEAK_MUL(LEAK_MUL), .STEP_W(STEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .step_o(step_o), .alu_en_o(alu_en_o), .mul_en_o(mul_en_o),
  .alu_opnd_o(alu_opnd_o), .mul_opnd_o(mul_opnd_o)
);

// File: tb/bind_ctrl_tb.sv
`timescale 1ns/1ps
module bind_ctrl_tb;
  localparam int NA = 12, NM = 8, NS = 8, NC = 24, SW = 5, W = 16;
  localparam logic [15:0] LA = 16'h5A3C, LM = 16'hC3A5;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [SW-1:0] cand_sel_i = '0;
  logic [NA-1:0][W-1:0] alu_bus_i;
  logic [NM-1:0][W-1:0] mul_bus_i;
  logic busy_o, done_o;
  logic [2:0] step_o;
  logic [NA-1:0] alu_en_o;
  logic [NM-1:0] mul_en_o;
  logic [NA-1:0][3:0] alu_slot_o;
  logic [NM-1:0][2:0] mul_slot_o;
  logic [NA-1:0][W-1:0] alu_opnd_o;
  logic [NM-1:0][W-1:0] mul_opnd_o;

  bind_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cand_sel_i(cand_sel_i),
    .alu_bus_i(alu_bus_i), .mul_bus_i(mul_bus_i), .busy_o(busy_o), .done_o(done_o),
    .step_o(step_o), .alu_en_o(alu_en_o), .mul_en_o(mul_en_o),
    .alu_slot_o(alu_slot_o), .mul_slot_o(mul_slot_o),
    .alu_opnd_o(alu_opnd_o), .mul_opnd_o(mul_opnd_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NA-1:0] exp_alu(input int c, input int s);
    int cnt = (5 * s + 3) % (NA + 1);
    for (int u = 0; u < NA; u++) exp_alu[u] = (((u + c * (s + 1)) % NA) < cnt);
  endfunction
  function automatic logic [NM-1:0] exp_mul(input int c, input int s);
    int cnt = (3 * s + 2) % (NM + 1);
    for (int u = 0; u < NM; u++) exp_mul[u] = (((u + c * (s + 2)) % NM) < cnt);
  endfunction

  task automatic check_opnd(input logic [NA-1:0] ea, input logic [NM-1:0] em);
    int k = 0;
    for (int u = 0; u < NA; u++) begin
      if (ea[u]) begin
        check(alu_opnd_o[u] == alu_bus_i[k] && alu_slot_o[u] == 4'(k), "R10 alu operand", {alu_slot_o[u], alu_opnd_o[u]}, {4'(k), alu_bus_i[k]});
        k++;
      end else
        check(alu_opnd_o[u] == LA && alu_slot_o[u] == 0, "R10 alu leak", {alu_slot_o[u], alu_opnd_o[u]}, LA);
    end
    k = 0;
    for (int u = 0; u < NM; u++) begin
      if (em[u]) begin
        check(mul_opnd_o[u] == mul_bus_i[k] && mul_slot_o[u] == 3'(k), "R10 mul operand", {mul_slot_o[u], mul_opnd_o[u]}, {3'(k), mul_bus_i[k]});
        k++;
      end else
        check(mul_opnd_o[u] == LM && mul_slot_o[u] == 0, "R10 mul leak", {mul_slot_o[u], mul_opnd_o[u]}, LM);
    end
  endtask

  // One run: sel at start, alt applied during run, poke pulses start while busy
  task automatic run(input int sel, input int alt, input bit poke);
    int c = (sel >= NC) ? 0 : sel;
    @(negedge clk); start_i = 1'b1; cand_sel_i = SW'(sel);
    @(negedge clk); start_i = 1'b0; if (poke) cand_sel_i = SW'(alt);
    for (int s = 0; s < NS; s++) begin
      check(busy_o && step_o == 3'(s), "R2 step", {busy_o, step_o}, {1'b1, 3'(s)});
      check(alu_en_o == exp_alu(c, s), (sel >= NC) ? "R8 alu enables" : (poke ? "R9 alu enables" : "R6 alu enables"), alu_en_o, exp_alu(c, s));
      check(mul_en_o == exp_mul(c, s), (sel >= NC) ? "R8 mul enables" : "R6 mul enables", mul_en_o, exp_mul(c, s));
      if (c == 0) check(alu_en_o == exp_alu(0, s), "R5 base alu", alu_en_o, exp_alu(0, s));
      check($countones(alu_en_o) == (5 * s + 3) % (NA + 1), "R7 alu count", $countones(alu_en_o), (5 * s + 3) % (NA + 1));
      check($countones(mul_en_o) == (3 * s + 2) % (NM + 1), "R7 mul count", $countones(mul_en_o), (3 * s + 2) % (NM + 1));
      check_opnd(exp_alu(c, s), exp_mul(c, s));
      start_i = poke && (s == 2 || s == NS - 1);   // R4 start while busy
      @(negedge clk);
    end
    start_i = 1'b0;
    check(done_o && !busy_o && alu_en_o == 0 && mul_en_o == 0, "R3 done cycle", {done_o, busy_o, alu_en_o}, {2'b10, 12'h0});
    check_opnd('0, '0);
    @(negedge clk);
    check(!done_o && !busy_o, poke ? "R4 no restart" : "R3 done one cycle", {done_o, busy_o}, 2'b00);
  endtask

  typedef struct packed { logic [7:0] sel; logic [7:0] alt; logic poke; } vec_t;
  localparam vec_t VECS [8] = '{
    '{8'd0, 8'd0, 1'b0}, '{8'd1, 8'd1, 1'b0}, '{8'd5, 8'd17, 1'b1}, '{8'd11, 8'd0, 1'b0},
    '{8'd23, 8'd2, 1'b1}, '{8'd24, 8'd24, 1'b0}, '{8'd31, 8'd7, 1'b1}, '{8'd13, 8'd31, 1'b1}
  };

  initial begin
    for (int k = 0; k < NA; k++) alu_bus_i[k] = 16'hA000 + 16'(k * 17);
    for (int k = 0; k < NM; k++) mul_bus_i[k] = 16'hB100 + 16'(k * 33);
    start_i = 1'b1;   // start during reset must not begin a run
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy_o && !done_o && alu_en_o == 0 && mul_en_o == 0, "R1 reset state", {busy_o, done_o, alu_en_o}, 0);
    check_opnd('0, '0);
    start_i = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R1 after release", {busy_o, done_o}, 0);
    for (int i = 0; i < 8; i++) run(int'(VECS[i].sel), int'(VECS[i].alt), VECS[i].poke);
    for (int c = 0; c < NC; c++) run(c, c, 1'b0);
    // idle with start low stays idle
    repeat (3) @(negedge clk);
    check(!busy_o && alu_en_o == 0, "R3 stays idle", {busy_o, alu_en_o}, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule